// File: doc/BRIEF.md
# Sleep State Transition Tracker

This block is a small register kept alive on standby power for a power-management controller. It remembers the sleep type that software most recently programmed. When a wake event occurs, it copies that value into a second field that records the state the system woke from. It also keeps a single flag that shows whether standby power stayed good while the working state was programmed. Firmware reads the flag and both fields after a resume to tell a clean wake from a power failure that happened before or during the resume.

Both sleep fields use one 2-bit code: 00 means S5, 01 means S4, 10 means S3, and 11 means the working state (S0). Only the resume-well reset clears the register. It has no platform reset input. Standby power-good affects nothing except the flag-clear rule below. The reset is asynchronous and active-low. Its release is synchronised, so it takes effect after `SYNC_STAGES` clock edges.

Top module: `slp_track_top`

## Requirements
- R1: While the resume-well reset is asserted, and for the synchronising edges after it is released, the readback is all zeros: both fields hold 00 (S5) and the flag is 0.
- R2: Bits 1:0 hold the last programmed code. A `slp_prog` strobe loads `slp_code` on the next edge. A register write loads `reg_wdata[1:0]` on the next edge only if no strobe arrives in the same cycle, because the strobe has priority.
- R3: A `wake_evt` copies the value that bits 1:0 hold before that edge into bits 3:2. This copy takes priority over a register write in the same cycle.
- R4: A register write with no `wake_evt` in the same cycle loads `reg_wdata[3:2]` into bits 3:2 on the next edge.
- R5: Bit 4 is set on the edge after any `slp_prog` strobe, whatever code the strobe carries. Register writes never change bit 4.
- R6: When `stby_pgood` is low and bits 1:0 hold 11 (working), bit 4 clears on the next edge. A `slp_prog` strobe in the same cycle overrides the clear, and the flag is set.
- R7: When `stby_pgood` is low and bits 1:0 hold 00, 01 or 10, bit 4 keeps its value. `stby_pgood` never changes bits 3:0.
- R8: `reg_rdata` shows {flag, resumed-from, last-programmed} in bits 4:0 with no delay. Bits 31:5 always read 0.
- R9: Both fields use one code: 00=S5, 01=S4, 10=S3, 11=S0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Standby-domain clock |
| rsm_rst_n | input | 1 | Resume-well reset, asynchronous, active-low |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 32 | Write data; only bits 3:0 are used |
| reg_rdata | output | 32 | Combinational readback |
| slp_prog | input | 1 | Sleep-type programming strobe |
| slp_code | input | 2 | Code carried by `slp_prog` |
| wake_evt | input | 1 | Resume event, one cycle |
| stby_pgood | input | 1 | Standby power-good, synchronous to `clk` |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `stby_pgood` has already been synchronised by the time it reaches the block, so a low level is meaningful in any cycle. Each assertion is checked only after the synchronised reset has released.

The stimulus changes inputs only on the falling clock edge. It draws `stby_pgood` lows, strobes, writes and wakes at random. It overlaps them often enough to reach every priority case. Directed phases hold the working code while power-good drops, and hold the sleep codes while it drops. One reset is applied in the middle of the run.

// File: rtl/slp_track_pkg.sv
package slp_track_pkg;
  typedef enum logic [1:0] {
    SLP_S5   = 2'b00,
    SLP_S4   = 2'b01,
    SLP_S3   = 2'b10,
    SLP_WORK = 2'b11
  } slp_code_e;

  localparam int LAST_LSB   = 0;
  localparam int RESUME_LSB = 2;
  localparam int FLAG_BIT   = 4;
  localparam int USED_BITS  = 5;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/slp_last_reg.sv
module slp_last_reg
  import slp_track_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_stb,
  input  logic [1:0] prog_code,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output logic [1:0] last_o
);
  logic [1:0] last_q;
  logic [1:0] last_d;
  logic       last_en;

  always_comb begin
    last_en = prog_stb | wr_en;
    last_d  = prog_stb ? prog_code : wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= SLP_S5;
    else if (last_en) last_q <= last_d;
  end

  assign last_o = last_q;

  AST_PROG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> last_q == $past(prog_code)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prog_stb) |=> last_q == $past(wr_code)); // R2
  AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !prog_stb) |=> $stable(last_q)); // R7
endmodule

// File: rtl/slp_resume_reg.sv
module slp_resume_reg
  import slp_track_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic [1:0] last_i,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output logic [1:0] resumed_o
);
  logic [1:0] res_q;
  logic [1:0] res_d;
  logic       res_en;

  always_comb begin
    res_en = wake | wr_en;
    res_d  = wake ? last_i : wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= SLP_S5;
    else if (res_en) res_q <= res_d;
  end

  assign resumed_o = res_q;

  AST_WAKE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> res_q == $past(last_i)); // R3
  AST_WRITE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wake) |=> res_q == $past(wr_code)); // R4
endmodule

// File: rtl/slp_flag_reg.sv
module slp_flag_reg
  import slp_track_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_stb,
  input  logic       pgood,
  input  logic [1:0] last_i,
  output logic       flag_o
);
  logic flag_q;
  logic flag_d;
  logic lost_in_work;

  always_comb begin
    lost_in_work = !pgood && (last_i == SLP_WORK);
    if (prog_stb)          flag_d = 1'b1;
    else if (lost_in_work) flag_d = 1'b0;
    else                   flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> flag_q); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_stb && !pgood && last_i == SLP_WORK) |=> !flag_q); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_stb && !pgood && last_i != SLP_WORK) |=> $stable(flag_q)); // R7
endmodule

// File: rtl/slp_track_top.sv
module slp_track_top
  import slp_track_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rsm_rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              slp_prog,
  input  logic [1:0]        slp_code,
  input  logic              wake_evt,
  input  logic              stby_pgood
);
  localparam int PAD_W = DATA_W - USED_BITS;

  logic       rst_n_s;
  logic [1:0] last_w;
  logic [1:0] resumed_w;
  logic       flag_w;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^reg_wdata[DATA_W-1:FLAG_BIT];

  slp_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (rsm_rst_n),
    .rst_n_o (rst_n_s)
  );

  slp_last_reg u_last (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .prog_stb  (slp_prog),
    .prog_code (slp_code),
    .wr_en     (reg_wr),
    .wr_code   (reg_wdata[LAST_LSB+1:LAST_LSB]),
    .last_o    (last_w)
  );

  slp_resume_reg u_resume (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wake      (wake_evt),
    .last_i    (last_w),
    .wr_en     (reg_wr),
    .wr_code   (reg_wdata[RESUME_LSB+1:RESUME_LSB]),
    .resumed_o (resumed_w)
  );

  slp_flag_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .prog_stb (slp_prog),
    .pgood    (stby_pgood),
    .last_i   (last_w),
    .flag_o   (flag_w)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign reg_rdata = {{PAD_W{1'b0}}, flag_w, resumed_w, last_w};
    end else begin : g_nopad
      assign reg_rdata = {flag_w, resumed_w, last_w};
    end
  endgenerate

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_rdata[DATA_W-1:USED_BITS] == '0); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n_s |-> reg_rdata == '0); // R1
endmodule

// File: tb/slp_track_top_tb_top.sv
module slp_track_top_tb_top;
  logic        clk = 1'b0;
  logic        rsm_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        slp_prog = 1'b0;
  logic [1:0]  slp_code = 2'b00;
  logic        wake_evt = 1'b0;
  logic        stby_pgood = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference state
  int m_last = 0, m_res = 0, m_flag = 0, m_rel = 0;

  always #2 clk = ~clk;

  slp_track_top dut_i (
    .clk(clk), .rsm_rst_n(rsm_rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .slp_prog(slp_prog), .slp_code(slp_code),
    .wake_evt(wake_evt), .stby_pgood(stby_pgood)
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      m_rel = 0; m_last = 0; m_res = 0; m_flag = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1; m_last = 0; m_res = 0; m_flag = 0;
    end else begin
      int old_last;
      old_last = m_last;
      if (slp_prog) m_flag = 1;
      else if (!stby_pgood && old_last == 3) m_flag = 0;
      if (slp_prog) m_last = int'(slp_code);
      else if (reg_wr) m_last = int'(reg_wdata[1:0]);
      if (wake_evt) m_res = old_last;
      else if (reg_wr) m_res = int'(reg_wdata[3:2]);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare on every falling edge (R8 upper bits, R2 last, R3 resumed, R5 flag)
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk(int'(reg_rdata[31:5]), 0, "R8 upper bits");
      chk(int'(reg_rdata[1:0]), m_last, "R2 last field");
      chk(int'(reg_rdata[3:2]), m_res, "R3 resumed field");
      chk(int'(reg_rdata[4]), m_flag, "R5 flag");
    end
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got %0d expected <100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic idle;
    reg_wr = 0; slp_prog = 0; wake_evt = 0; stby_pgood = 1;
  endtask

  task automatic step(input bit wr, input logic [3:0] wd, input bit pr,
                      input logic [1:0] cd, input bit wk, input bit pg);
    @(negedge clk);
    #1;
    reg_wr = wr; reg_wdata = {28'hABCDEF1, wd}; slp_prog = pr; slp_code = cd;
    wake_evt = wk; stby_pgood = pg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state visible
    chk(int'(reg_rdata), 0, "R1 reset value");
    #1 rsm_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 codes: program S0 (11), drop pgood -> R6 clear
    step(0, 4'h0, 1, 2'b11, 0, 1);
    step(0, 4'h0, 0, 2'b00, 0, 0);
    step(0, 4'h0, 0, 2'b00, 0, 1);
    @(negedge clk); chk(int'(reg_rdata[4]), 0, "R6 flag cleared in S0");
    // R7: S3 (10) programmed, pgood low keeps flag
    step(0, 4'h0, 1, 2'b10, 0, 1);
    step(0, 4'h0, 0, 2'b00, 0, 0);
    step(0, 4'h0, 0, 2'b00, 0, 0);
    step(0, 4'h0, 0, 2'b00, 0, 1);
    @(negedge clk); chk(int'(reg_rdata[4:0]), 5'h12, "R7 flag kept in S3");
    // R6 override: strobe and pgood low same cycle in S0
    step(0, 4'h0, 1, 2'b11, 0, 1);
    step(0, 4'h0, 1, 2'b11, 0, 0);
    step(0, 4'h0, 0, 2'b00, 0, 1);
    @(negedge clk); chk(int'(reg_rdata[4]), 1, "R6 strobe beats clear");
    // R3 vs R4 priority: wake and write together
    step(1, 4'b0101, 0, 2'b00, 1, 1);
    step(0, 4'h0, 0, 2'b00, 0, 1);
    @(negedge clk); chk(int'(reg_rdata[3:2]), 3, "R3 wake beats write");
    // R4: write alone
    step(1, 4'b1000, 0, 2'b00, 0, 1);
    step(0, 4'h0, 0, 2'b00, 0, 1);
    @(negedge clk); chk(int'(reg_rdata[3:0]), 4'b1000, "R4 write resumed field");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) == 0, 4'($urandom), $urandom_range(0, 4) == 0,
           2'($urandom), $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0);
      if (i == 1500) begin
        @(negedge clk); #1 rsm_rst_n = 1'b0; idle();
        @(negedge clk); chk(int'(reg_rdata), 0, "R1 mid-run reset");
        #1 rsm_rst_n = 1'b1;
      end
    end
    @(negedge clk); #1 idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule